// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block sits behind a CAN frame receiver that has already decoded each frame into its fields. For every incoming frame it picks one of sixteen mailboxes, stores the identifier, control bits and payload there, and marks that mailbox as holding a message. Software sees the mailboxes through a small word-addressed register port. There it sets each mailbox's mode, reads back status, identifier and data, and re-arms groups of mailboxes with one write of a bit mask.

The placement rule is fixed. A frame goes to the lowest-numbered receive mailbox that is still empty. If every receive mailbox is full, the lowest-numbered full mailbox in overwrite mode takes the frame and records that an unread message was lost. If no mailbox can take the frame, it is discarded and a sticky flag records the loss. Each mailbox's ready flag is also driven out as its interrupt line.

Register map (word addresses on `reg_addr`):
- Address 0x00 is the global status register. Bits 15:0 hold the mailbox ready flags and bit 31 holds the overflow flag.
- Address 0x01 is the transfer-command register, which is write-only.
- Mailbox n sits at 0x80 + 8·n. The word select is offset 0 for mode, 1 for identifier, 2 for status, 3 for data low and 4 for data high.

Top module: `can_rx_mailbox`

## Requirements
- R1: Each mailbox mode sits in bits 26:24 of its mode word (offset 0) and resets to 0. The encodings are 0 disabled, 1 receive, 2 receive with overwrite, 3 transmit, 4 consumer and 5 producer. Only modes 1 and 2 are receive modes.
- R2: A valid frame is stored in the lowest-numbered mailbox whose mode is 1 or 2 and whose ready flag is clear. That mailbox's ready flag is set on the clock edge that samples `rx_valid`.
- R3: If no receive mailbox is empty, the frame replaces the contents of the lowest-numbered full mailbox in mode 2. That mailbox's lost-message bit (status bit 24) is then set.
- R4: If no mailbox can take the frame, the frame is discarded, no mailbox changes, and the overflow flag is set. The flag is visible on `rx_overflow` and in global status bit 31, and it stays set until a write to address 0x00 with bit 31 set.
- R5: A write to address 0x01 re-arms, in one cycle, every receive-mode mailbox whose bit is set in the written mask. Re-arming clears that mailbox's ready and lost-message bits. Mailboxes that are not selected, or that are not in a receive mode, keep their flags.
- R6: The status word (offset 2) holds the frame DLC in bits 19:16, the RTR flag in bit 20, ready in bit 23 and lost-message in bit 24. All other bits read as zero.
- R7: The identifier word (offset 1) holds a standard 11-bit identifier shifted left by 18. It holds an extended 29-bit identifier unshifted in bits 28:0, with bit 29 set.
- R8: Data low (offset 3) holds payload bytes 0 to 3 and data high (offset 4) holds bytes 4 to 7, with byte 0 taken from `rx_data[7:0]`. An RTR frame leaves both data words unchanged.
- R9: Bit i of the global status word and bit i of `mb_irq` both equal the ready flag of mailbox i.
- R10: A read returns its word on `reg_rdata` with `reg_rvalid` high one cycle after `reg_re`. Unmapped addresses read as zero.
- R11: A mailbox in mode 0, 3, 4 or 5 never receives a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Decoded frame present this cycle |
| rx_id | input | 29 | Identifier (11 bits in 10:0 when standard) |
| rx_ide | input | 1 | Extended identifier flag |
| rx_rtr | input | 1 | Remote request flag |
| rx_dlc | input | 4 | Data length code |
| rx_data | input | 64 | Payload, byte 0 in bits 7:0 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| mb_irq | output | 16 | Per-mailbox interrupt (ready flags) |
| rx_overflow | output | 1 | Sticky lost-frame flag |

## Verification
The hardest state to reach is the one where every receive mailbox is full. Overwrite and drop only happen there. The stimulus fills all six receive mailboxes one frame at a time and confirms the lowest-first placement after each frame. It then sends one more frame so that the overwrite mailbox absorbs it. Later it turns the overwrite mailbox into a plain receive mailbox and fills the bank again, so the next frame is dropped. It also turns a full mailbox into a transmit mailbox before a re-arm that selects it, which shows that non-receive mailboxes ignore the transfer command.

// File: rtl/can_rxmb_pkg.sv
package can_rxmb_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_RX    = 3'd1,
    MODE_RXOVR = 3'd2,
    MODE_TX    = 3'd3,
    MODE_CONS  = 3'd4,
    MODE_PROD  = 3'd5
  } mb_mode_e;

  localparam int MODE_LSB    = 24;
  localparam int EXT_ID_BIT  = 29;
  localparam int STD_SHIFT   = 18;

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } frame_t;

  function automatic logic [31:0] pack_id(input frame_t f);
    logic [31:0] w;
    if (f.ide) begin
      w = {3'b000, f.id};
      w[EXT_ID_BIT] = 1'b1;
    end else begin
      w = {21'd0, f.id[10:0]} << STD_SHIFT;
    end
    return w;
  endfunction

  function automatic logic is_rx_mode(input logic [2:0] m);
    return (m == MODE_RX) || (m == MODE_RXOVR);
  endfunction

endpackage

// File: rtl/can_rxmb_pick.sv
module can_rxmb_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/can_rxmb_slot.sv
module can_rxmb_slot
  import can_rxmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_sync_n,
  input  logic        mode_we,
  input  logic [2:0]  mode_wdata,
  input  logic        store,
  input  logic        rearm,
  input  frame_t      frm,
  output logic [2:0]  mode,
  output logic        ready,
  output logic        lost,
  output logic [3:0]  dlc,
  output logic        rtr,
  output logic [31:0] id_word,
  output logic [31:0] data_lo,
  output logic [31:0] data_hi
);
  logic [2:0]  mode_q, mode_n;
  logic        ready_q, ready_n;
  logic        lost_q, lost_n;
  logic [3:0]  dlc_q, dlc_n;
  logic        rtr_q, rtr_n;
  logic [31:0] id_q, id_n;
  logic [31:0] lo_q, lo_n;
  logic [31:0] hi_q, hi_n;
  logic        rx_capable;

  assign rx_capable = is_rx_mode(mode_q);

  always_comb begin
    mode_n  = mode_q;
    ready_n = ready_q;
    lost_n  = lost_q;
    dlc_n   = dlc_q;
    rtr_n   = rtr_q;
    id_n    = id_q;
    lo_n    = lo_q;
    hi_n    = hi_q;
    if (mode_we) mode_n = mode_wdata;
    if (rearm && rx_capable) begin
      ready_n = 1'b0;
      lost_n  = 1'b0;
    end
    if (store) begin
      lost_n  = ready_n;
      ready_n = 1'b1;
      dlc_n   = frm.dlc;
      rtr_n   = frm.rtr;
      id_n    = pack_id(frm);
      if (!frm.rtr) begin
        lo_n = frm.data[31:0];
        hi_n = frm.data[63:32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q  <= MODE_OFF;
      ready_q <= 1'b0;
      lost_q  <= 1'b0;
      dlc_q   <= '0;
      rtr_q   <= 1'b0;
      id_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      mode_q  <= mode_n;
      ready_q <= ready_n;
      lost_q  <= lost_n;
      dlc_q   <= dlc_n;
      rtr_q   <= rtr_n;
      id_q    <= id_n;
      lo_q    <= lo_n;
      hi_q    <= hi_n;
    end
  end

  assign mode    = mode_q;
  assign ready   = ready_q;
  assign lost    = lost_q;
  assign dlc     = dlc_q;
  assign rtr     = rtr_q;
  assign id_word = id_q;
  assign data_lo = lo_q;
  assign data_hi = hi_q;

  // R3: a lost-message mark only exists on a mailbox that holds a message
  p_lost_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lost_q |-> ready_q);

  // R2: storing a frame leaves the mailbox full
  p_store_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    store |=> ready_q);

  // R8: remote frames do not disturb the payload
  p_rtr_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (store && frm.rtr) |=> ($stable(lo_q) && $stable(hi_q)));

  // R5: a re-arm without a new frame empties a receive mailbox
  p_rearm_clears_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rearm && rx_capable && !store) |=> (!ready_q && !lost_q));

endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
  import can_rxmb_pkg::*;
#(
  parameter int NMB = 16,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [28:0]   rx_id,
  input  logic          rx_ide,
  input  logic          rx_rtr,
  input  logic [3:0]    rx_dlc,
  input  logic [63:0]   rx_data,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  output logic [NMB-1:0] mb_irq,
  output logic          rx_overflow
);
  localparam int MBW      = $clog2(NMB);
  localparam int SEL_W    = 3;
  localparam int GADDR_W  = AW - 1;
  localparam int GSTAT_PAD = 31 - NMB;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  frame_t frm;
  assign frm = '{id: rx_id, ide: rx_ide, rtr: rx_rtr, dlc: rx_dlc, data: rx_data};

  // register decode
  logic              mb_region;
  logic [MBW-1:0]    mb_idx;
  logic [SEL_W-1:0]  mb_sel;
  logic [GADDR_W-1:0] g_addr;
  logic              wr_gstat, wr_tcr;
  logic [NMB-1:0]    mode_we_v, rearm_v;

  assign mb_region = reg_addr[AW-1];
  assign mb_sel    = reg_addr[SEL_W-1:0];
  assign mb_idx    = reg_addr[SEL_W +: MBW];
  assign g_addr    = reg_addr[GADDR_W-1:0];
  assign wr_gstat  = reg_we && !mb_region && (g_addr == GADDR_W'(0));
  assign wr_tcr    = reg_we && !mb_region && (g_addr == GADDR_W'(1));
  assign rearm_v   = wr_tcr ? reg_wdata[NMB-1:0] : '0;

  always_comb begin
    mode_we_v = '0;
    if (reg_we && mb_region && (mb_sel == SEL_W'(0)))
      mode_we_v[mb_idx] = 1'b1;
  end

  // mailbox bank
  logic [2:0]  mode_a [NMB];
  logic [3:0]  dlc_a  [NMB];
  logic [31:0] id_a   [NMB];
  logic [31:0] lo_a   [NMB];
  logic [31:0] hi_a   [NMB];
  logic [NMB-1:0] ready_v, lost_v, rtr_v, rx_ok_v, ovr_ok_v, store_v;

  genvar g;
  generate
    for (g = 0; g < NMB; g++) begin : g_slot
      can_rxmb_slot u_slot (
        .clk        (clk),
        .rst_sync_n (rst_sync_n),
        .mode_we    (mode_we_v[g]),
        .mode_wdata (reg_wdata[MODE_LSB +: 3]),
        .store      (store_v[g]),
        .rearm      (rearm_v[g]),
        .frm        (frm),
        .mode       (mode_a[g]),
        .ready      (ready_v[g]),
        .lost       (lost_v[g]),
        .dlc        (dlc_a[g]),
        .rtr        (rtr_v[g]),
        .id_word    (id_a[g]),
        .data_lo    (lo_a[g]),
        .data_hi    (hi_a[g])
      );
      assign rx_ok_v[g]  = is_rx_mode(mode_a[g]);
      assign ovr_ok_v[g] = (mode_a[g] == MODE_RXOVR) && ready_v[g];
    end
  endgenerate

  // destination choice: empty receive mailboxes first, then overwrite
  logic [NMB-1:0] free_v, gnt_free, gnt_ovr;
  logic           any_free, any_ovr, drop;

  assign free_v = rx_ok_v & ~ready_v;

  can_rxmb_pick #(.N(NMB)) u_pick_free (.req(free_v),   .gnt(gnt_free), .any(any_free));
  can_rxmb_pick #(.N(NMB)) u_pick_ovr  (.req(ovr_ok_v), .gnt(gnt_ovr),  .any(any_ovr));

  assign store_v = !rx_valid ? '0 : (any_free ? gnt_free : gnt_ovr);
  assign drop    = rx_valid && !any_free && !any_ovr;

  // sticky overflow
  logic ovf_q, ovf_n;
  always_comb begin
    ovf_n = ovf_q;
    if (wr_gstat && reg_wdata[31]) ovf_n = 1'b0;
    if (drop)                      ovf_n = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovf_q <= 1'b0;
    else             ovf_q <= ovf_n;
  end

  // read path
  logic [31:0] rd_n, rd_q;
  logic        rv_q;
  logic [31:0] gstat;
  assign gstat = {ovf_q, {GSTAT_PAD{1'b0}}, ready_v};

  always_comb begin
    rd_n = '0;
    if (mb_region) begin
      case (mb_sel)
        3'd0: rd_n = {5'd0, mode_a[mb_idx], 24'd0};
        3'd1: rd_n = id_a[mb_idx];
        3'd2: rd_n = {7'd0, lost_v[mb_idx], ready_v[mb_idx], 2'b00,
                      rtr_v[mb_idx], dlc_a[mb_idx], 16'd0};
        3'd3: rd_n = lo_a[mb_idx];
        3'd4: rd_n = hi_a[mb_idx];
        default: rd_n = '0;
      endcase
    end else if (g_addr == GADDR_W'(0)) begin
      rd_n = gstat;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= reg_re;
      if (reg_re) rd_q <= rd_n;
    end
  end

  assign reg_rdata   = rd_q;
  assign reg_rvalid  = rv_q;
  assign mb_irq      = ready_v;
  assign rx_overflow = ovf_q;

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata[30:27], reg_wdata[23:NMB]};

  // R2: at most one mailbox takes a frame
  p_store_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(store_v));

  // R2: a frame placed in an empty mailbox skips no lower empty one
  p_store_lowest_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    |(store_v & free_v) |-> (((store_v - NMB'(1)) & free_v) == '0));

  // R11: only receive-mode mailboxes take frames
  p_store_only_rx_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (store_v & ~rx_ok_v) == '0);

  // R4: the overflow flag holds until cleared by software
  p_overflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_q && !(wr_gstat && reg_wdata[31])) |=> ovf_q);

  // R4: a discarded frame raises the flag on the next cycle
  p_drop_flags_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drop |=> ovf_q);

  // R10: read data valid follows the read strobe by one cycle
  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_re |=> reg_rvalid);

endmodule

// File: tb/sim_can_rx_mailbox.sv
`timescale 1ns/1ps
module sim_can_rx_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [28:0] rx_id = '0;
  logic        rx_ide = 1'b0;
  logic        rx_rtr = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [15:0] mb_irq;
  logic        rx_overflow;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  can_rx_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
    .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .mb_irq(mb_irq), .rx_overflow(rx_overflow)
  );

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (reg_rvalid) begin
      logic [31:0] e;
      string t;
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected read data: actual %08h expected none", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %08h expected %08h", t, reg_rdata, e);
        end
      end
    end
  end

  function automatic logic [7:0] mba(input int mb, input int sel);
    return 8'h80 | 8'(mb << 3) | 8'(sel);
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string t);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(t);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic send(input logic [28:0] id, input logic ide, input logic rtr,
                      input logic [3:0] dlc, input logic [63:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #(8ns * 100000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R9 irq after reset", 32'(mb_irq), 32'h0);
    chk("R4 overflow after reset", 32'(rx_overflow), 32'h0);
    rd(8'h00, 32'h0, "R9 global status after reset");
    rd(mba(3, 0), 32'h0, "R1 mode after reset");

    // configuration
    for (int i = 1; i <= 5; i++) wr(mba(i, 0), 32'h01000000);
    wr(mba(6, 0), 32'h02000000);
    wr(mba(7, 0), 32'h03000000);
    rd(mba(6, 0), 32'h02000000, "R1 mode readback");

    // standard data frame -> mailbox 1
    send(29'h123, 1'b0, 1'b0, 4'd8, 64'h8877665544332211);
    chk("R9 irq after first frame", 32'(mb_irq), 32'h0002);
    rd(mba(1, 1), 32'h048C0000, "R7 standard id");
    rd(mba(1, 2), 32'h00880000, "R6 status data frame");
    rd(mba(1, 3), 32'h44332211, "R8 data low");
    rd(mba(1, 4), 32'h88776655, "R8 data high");

    // extended remote frame -> mailbox 2, data untouched
    send(29'h1ABCDEF5, 1'b1, 1'b1, 4'd3, 64'hFFFFFFFFFFFFFFFF);
    rd(mba(2, 1), 32'h3ABCDEF5, "R7 extended id");
    rd(mba(2, 2), 32'h00930000, "R6 status remote frame");
    rd(mba(2, 3), 32'h0, "R8 remote frame data low");

    // fill remaining receive mailboxes in order
    send(29'h010, 1'b0, 1'b0, 4'd1, 64'h1);
    send(29'h011, 1'b0, 1'b0, 4'd1, 64'h2);
    send(29'h012, 1'b0, 1'b0, 4'd1, 64'h3);
    rd(mba(5, 1), 32'h00480000, "R2 lowest free order");
    send(29'h7FF, 1'b0, 1'b0, 4'd2, 64'hAAAA);
    chk("R2 irq all receive full", 32'(mb_irq), 32'h007E);

    // overwrite mailbox absorbs the next frame
    send(29'h55, 1'b1, 1'b0, 4'd5, 64'h12345678);
    rd(mba(6, 2), 32'h01850000, "R3 lost bit set on overwrite");
    rd(mba(6, 1), 32'h20000055, "R3 new id replaced old");
    rd(mba(6, 3), 32'h12345678, "R3 new data replaced old");
    chk("R3 no overflow on overwrite", 32'(rx_overflow), 32'h0);
    rd(8'h00, 32'h0000007E, "R9 global status full");

    // mailbox 5 turned into transmit keeps its flag on re-arm
    wr(mba(5, 0), 32'h03000000);
    wr(8'h01, 32'h00000025);
    rd(8'h00, 32'h0000007A, "R5 re-arm selected receive only");
    chk("R5 irq after re-arm", 32'(mb_irq), 32'h007A);
    wr(mba(5, 0), 32'h01000000);

    // freed mailbox 2 is the lowest free; disabled mailbox 0 skipped
    send(29'h200, 1'b0, 1'b0, 4'd1, 64'h9);
    rd(mba(2, 1), 32'h08000000, "R2 refill lowest freed");
    rd(mba(0, 2), 32'h0, "R11 disabled mailbox untouched");

    // re-arm overwrite mailbox clears lost bit
    wr(8'h01, 32'h00000040);
    rd(mba(6, 2), 32'h00050000, "R5 re-arm clears ready and lost");

    // plain receive everywhere, then overflow
    wr(mba(6, 0), 32'h01000000);
    send(29'h300, 1'b0, 1'b0, 4'd0, 64'h0);
    send(29'h301, 1'b0, 1'b0, 4'd2, 64'hDEAD);
    chk("R4 overflow output", 32'(rx_overflow), 32'h1);
    rd(8'h00, 32'h8000007E, "R4 overflow in global status");
    rd(mba(1, 3), 32'h44332211, "R4 dropped frame changes nothing");
    rd(mba(6, 1), 32'h0C000000, "R4 last mailbox keeps its frame");
    rd(mba(7, 2), 32'h0, "R11 transmit mailbox untouched");
    wr(8'h00, 32'h80000000);
    chk("R4 overflow cleared", 32'(rx_overflow), 32'h0);

    // remote frame into a mailbox with old payload
    wr(8'h01, 32'h00000002);
    send(29'h055, 1'b0, 1'b1, 4'd4, 64'h0123456789ABCDEF);
    rd(mba(1, 2), 32'h00940000, "R6 remote status");
    rd(mba(1, 3), 32'h44332211, "R8 remote keeps data low");
    rd(mba(1, 4), 32'h88776655, "R8 remote keeps data high");

    // unmapped addresses
    rd(8'h05, 32'h0, "R10 unmapped global");
    rd(mba(1, 7), 32'h0, "R10 unmapped mailbox word");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10 missing read data: actual %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule